// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block sits beside a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It turns per-stage fault reports and an external interrupt line into one orderly trap. Four stages can flag a fault, each with the PC of the instruction it holds. Fetch reports instruction page faults and protection violations. Decode reports undefined opcodes. Execute reports arithmetic overflow. Memory reports data page faults, protection violations and memory errors. When faults appear, the controller commits the oldest one. It saves that instruction's PC for a later restart and records a cause code. It flushes the faulting instruction and everything younger, holds register-file and memory writes off until the trap reaches writeback, and steers fetch to a fixed handler address.

External interrupts are handled differently. Fetch is held so that the instructions already in flight drain out. The trap is committed only once every stage is empty. The saved PC is then the next fetch address, so no instruction is lost or repeated. A fault raised by an in-flight instruction during the drain is older than the interrupt and takes precedence.

Top module: `excp_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs rest at these values: redirect, flush mask, irq acknowledge, fetch hold, saved PC and cause are all zero, and write enable is one.
- R2: A fault flag in stage s (fault bit 0 fetch, 1 decode, 2 execute, 3 memory), seen while writes are enabled, gives one cycle later a redirect pulse. In that cycle the redirect PC is the handler parameter, the saved PC is stage s's PC (slice s of the packed PC bus), and the cause is s: 0 fetch fault, 1 illegal opcode, 2 overflow, 3 data fault.
- R3: When several stages fault in the same cycle, the deepest stage wins: memory over execute over decode over fetch.
- R4: In the redirect cycle of a fault the flush mask (bit 0 fetch up to bit 4 writeback) has bits 0 to min(s+1,4) set and the rest clear. Outside redirect cycles it is zero.
- R5: After a fault in stage s, write enable is low for exactly 4-s cycles, starting with the redirect cycle, and then returns high.
- R6: Fault flags raised while write enable is low are ignored. No redirect follows, and the saved PC and cause stay unchanged.
- R7: When the interrupt input is high with no fault and writes enabled, fetch hold rises one cycle later. It stays high while any bit of the busy vector is set.
- R8: In the cycle after fetch hold is high and busy is all zero, the controller emits a redirect with cause 4, the resume PC as saved PC, and a one-cycle irq acknowledge. In that cycle fetch hold is low, write enable stays high and the flush mask is zero.
- R9: A fault seen in the same cycle as a new interrupt, or during a drain, is taken as in R2 and drops fetch hold.
- R10: A fault redirect lasts one cycle, and the saved PC and cause hold their values between commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 4 | Fault flags, bit 0 fetch to bit 3 memory |
| stage_pc_i | input | 4*PC_W | Packed PCs, slice s belongs to fault bit s |
| busy_i | input | 5 | Stage occupancy, bit 0 fetch to bit 4 writeback |
| resume_pc_i | input | PC_W | Next fetch address, saved on interrupt |
| irq_i | input | 1 | External interrupt request, level |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | PC_W | Redirect target (handler address) |
| epc_o | output | PC_W | Saved restart PC |
| cause_o | output | 3 | Trap cause code |
| flush_o | output | 5 | Stage kill mask for the redirect cycle |
| wr_en_o | output | 1 | Architectural write permission |
| fetch_hold_o | output | 1 | Stop fetching while draining |
| irq_ack_o | output | 1 | Interrupt taken pulse |

## Verification
Every result is registered. A fault is therefore visible exactly one cycle after the flags are driven: redirect, saved PC, cause and flush mask all appear then. Write enable is then low for 4-s cycles counted from that redirect cycle. Fetch hold rises one cycle after the interrupt. The interrupt redirect comes one cycle after the first held cycle that sees busy at zero. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check lands one rising edge after its stimulus. It walks the write-block window cycle by cycle, feeding random fault noise that must be ignored.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int unsigned NSTG    = 5;   // fetch, decode, execute, memory, writeback
  localparam int unsigned NSRC    = 4;   // stages able to fault
  localparam int unsigned CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CS_FETCH  = 3'd0,
    CS_DECODE = 3'd1,
    CS_ARITH  = 3'd2,
    CS_DATA   = 3'd3,
    CS_EXTIRQ = 3'd4
  } cause_e;

  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } mode_e;
endpackage

// File: rtl/excp_prio.sv
module excp_prio #(
  parameter int unsigned NSRC  = 4,
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  flag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // Higher index is a deeper, older stage: the last set bit wins.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (flag_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // The winner is set and no deeper stage is set.
  always_comb begin
    if (hit_o) begin
      assert_deepest_R3: assert ((flag_i >> idx_o) == NSRC'(1));
    end
  end
endmodule

// File: rtl/excp_retire.sv
module excp_retire #(
  parameter int unsigned NSTG  = 5,
  localparam int unsigned CNT_W = $clog2(NSTG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             block_o
);
  logic [CNT_W-1:0] cnt_q;

  // Counts the cycles until the trap bubble leaves writeback.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign block_o = (cnt_q != '0);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NSTG - 1));
  assert_block_start_R5: assert property (@(posedge clk) disable iff (rst)
    (load_i && len_i != '0) |=> block_o);
  assert_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !block_o);
endmodule

// File: rtl/excp_drain.sv
module excp_drain
  import excp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic abort_i,
  input  logic empty_i,
  output logic hold_o,
  output logic commit_o
);
  mode_e st_q;

  assign hold_o   = (st_q == ST_DRAIN);
  assign commit_o = (st_q == ST_DRAIN) && empty_i && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_RUN;
    end else begin
      case (st_q)
        ST_RUN:   if (req_i) st_q <= ST_DRAIN;
        ST_DRAIN: if (abort_i || empty_i) st_q <= ST_RUN;
        default:  st_q <= ST_RUN;
      endcase
    end
  end

  assert_hold_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_o && !empty_i && !abort_i) |=> hold_o);
  assert_abort_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_o && abort_i) |=> !hold_o);
endmodule

// File: rtl/excp_ctrl.sv
module excp_ctrl
  import excp_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(32'h0000_0180)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      fault_i,
  input  logic [NSRC*PC_W-1:0] stage_pc_i,
  input  logic [NSTG-1:0]      busy_i,
  input  logic [PC_W-1:0]      resume_pc_i,
  input  logic                 irq_i,
  output logic                 redirect_o,
  output logic [PC_W-1:0]      redirect_pc_o,
  output logic [PC_W-1:0]      epc_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [NSTG-1:0]      flush_o,
  output logic                 wr_en_o,
  output logic                 fetch_hold_o,
  output logic                 irq_ack_o
);
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned CNT_W = $clog2(NSTG);
  localparam logic [CNT_W-1:0] LAST_STG = CNT_W'(NSTG - 1);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             blocked;
  logic             take_fault;
  logic             drain_req;
  logic             irq_commit;
  logic             hold;
  logic [PC_W-1:0]  sel_pc;
  logic [CNT_W-1:0] blk_len;
  logic [NSTG-1:0]  kill_mask;

  logic             redirect_q;
  logic [PC_W-1:0]  target_q;
  logic [PC_W-1:0]  epc_q;
  cause_e           cause_q;
  logic [NSTG-1:0]  flush_q;
  logic             ack_q;

  excp_prio #(.NSRC(NSRC)) u_prio (
    .flag_i (fault_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  excp_retire #(.NSTG(NSTG)) u_retire (
    .clk     (clk),
    .rst     (rst),
    .load_i  (take_fault),
    .len_i   (blk_len),
    .block_o (blocked)
  );

  excp_drain u_drain (
    .clk      (clk),
    .rst      (rst),
    .req_i    (drain_req),
    .abort_i  (take_fault),
    .empty_i  (busy_i == '0),
    .hold_o   (hold),
    .commit_o (irq_commit)
  );

  assign take_fault = hit && !blocked;
  assign drain_req  = irq_i && !blocked && !hit && !ack_q;
  assign sel_pc     = stage_pc_i[int'(idx)*PC_W +: PC_W];
  assign blk_len    = LAST_STG - CNT_W'(idx);

  // The faulting instruction has moved one stage on when the mask applies.
  always_comb begin
    for (int i = 0; i < int'(NSTG); i++) begin
      kill_mask[i] = (i <= int'(idx) + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_q <= 1'b0;
      target_q   <= '0;
      epc_q      <= '0;
      cause_q    <= CS_FETCH;
      flush_q    <= '0;
      ack_q      <= 1'b0;
    end else begin
      redirect_q <= take_fault || irq_commit;
      flush_q    <= take_fault ? kill_mask : '0;
      ack_q      <= irq_commit;
      if (take_fault) begin
        target_q <= HANDLER_PC;
        epc_q    <= sel_pc;
        cause_q  <= cause_e'(CAUSE_W'(idx));
      end else if (irq_commit) begin
        target_q <= HANDLER_PC;
        epc_q    <= resume_pc_i;
        cause_q  <= CS_EXTIRQ;
      end
    end
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = target_q;
  assign epc_o         = epc_q;
  assign cause_o       = cause_q;
  assign flush_o       = flush_q;
  assign wr_en_o       = !blocked;
  assign fetch_hold_o  = hold;
  assign irq_ack_o     = ack_q;

  assert_fault_blocks_wr_R5: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && cause_o != CS_EXTIRQ) |-> !wr_en_o);
  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && cause_o != CS_EXTIRQ) |=> !redirect_o);
  assert_epc_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !redirect_o |-> ($stable(epc_o) && $stable(cause_o)));
  assert_flush_only_redirect_R4: assert property (@(posedge clk) disable iff (rst)
    (flush_o != '0) |-> (redirect_o && flush_o[0]));
  assert_irq_clean_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> (redirect_o && cause_o == CS_EXTIRQ && wr_en_o && flush_o == '0));
  assert_hold_vs_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    !(redirect_o && fetch_hold_o));
  assert_cause_range_R2: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (cause_o <= CS_EXTIRQ && redirect_pc_o == HANDLER_PC));
endmodule

// File: tb/test_excp_ctrl.sv
`timescale 1ns/1ps
module test_excp_ctrl;
  localparam int PC_W = 32;
  localparam logic [31:0] HND = 32'h0000_0180;

  logic            clk = 1'b0;
  logic            rst;
  logic [3:0]      fault_i;
  logic [4*32-1:0] stage_pc_i;
  logic [4:0]      busy_i;
  logic [31:0]     resume_pc_i;
  logic            irq_i;
  logic            redirect_o;
  logic [31:0]     redirect_pc_o;
  logic [31:0]     epc_o;
  logic [2:0]      cause_o;
  logic [4:0]      flush_o;
  logic            wr_en_o;
  logic            fetch_hold_o;
  logic            irq_ack_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  excp_ctrl #(.PC_W(PC_W), .HANDLER_PC(HND)) i_excp_ctrl (
    .clk(clk), .rst(rst), .fault_i(fault_i), .stage_pc_i(stage_pc_i),
    .busy_i(busy_i), .resume_pc_i(resume_pc_i), .irq_i(irq_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .epc_o(epc_o),
    .cause_o(cause_o), .flush_o(flush_o), .wr_en_o(wr_en_o),
    .fetch_hold_o(fetch_hold_o), .irq_ack_o(irq_ack_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int deepest(input logic [3:0] f);
    int d = -1;
    for (int i = 0; i < 4; i++) if (f[i]) d = i;
    return d;
  endfunction

  function automatic logic [4:0] kill_of(input int s);
    logic [4:0] m;
    for (int i = 0; i < 5; i++) m[i] = (i <= s + 1);
    return m;
  endfunction

  task automatic fill_pcs(output logic [31:0] pcs [4]);
    for (int i = 0; i < 4; i++) begin
      pcs[i] = $urandom & 32'hFFFF_FFFC;
      stage_pc_i[i*32 +: 32] = pcs[i];
    end
  endtask

  // R2 R3 R4 R5 R6 R10: one fault event followed by the blocked window
  task automatic fault_trial(input logic [3:0] f, input bit noise);
    logic [31:0] pcs [4];
    int s;
    int blen;
    s = deepest(f);
    blen = 4 - s;
    @(negedge clk);
    fill_pcs(pcs);
    fault_i = f;
    @(negedge clk);
    chk("R2", "redirect", 64'(redirect_o), 64'd1);
    chk("R2", "target", 64'(redirect_pc_o), 64'(HND));
    chk("R3", "epc", 64'(epc_o), 64'(pcs[s]));
    chk("R3", "cause", 64'(cause_o), 64'(s));
    chk("R4", "flush", 64'(flush_o), 64'(kill_of(s)));
    chk("R5", "wr_en in redirect cycle", 64'(wr_en_o), 64'd0);
    for (int j = 0; j < blen; j++) begin
      fault_i = noise ? 4'($urandom) : 4'd0;
      for (int i = 0; i < 4; i++) stage_pc_i[i*32 +: 32] = $urandom;
      @(negedge clk);
      chk("R10", "redirect pulse", 64'(redirect_o), 64'd0);
      chk("R4", "flush after", 64'(flush_o), 64'd0);
      chk("R6", "epc kept", 64'(epc_o), 64'(pcs[s]));
      chk("R6", "cause kept", 64'(cause_o), 64'(s));
      chk("R5", "wr_en window", 64'(wr_en_o), 64'((j + 1) >= blen));
    end
    fault_i = 4'd0;
    @(negedge clk);
    chk("R6", "no late redirect", 64'(redirect_o), 64'd0);
    chk("R5", "wr_en back", 64'(wr_en_o), 64'd1);
  endtask

  // R7 R8: interrupt drained for nbusy cycles
  task automatic irq_trial(input int nbusy);
    logic [31:0] rpc;
    @(negedge clk);
    rpc = $urandom & 32'hFFFF_FFFC;
    resume_pc_i = rpc;
    irq_i = 1'b1;
    busy_i = 5'($urandom);
    @(negedge clk);
    chk("R7", "hold rises", 64'(fetch_hold_o), 64'd1);
    chk("R7", "no early redirect", 64'(redirect_o), 64'd0);
    for (int i = 0; i < nbusy; i++) begin
      busy_i = (i == 0) ? 5'b10000 : 5'($urandom_range(1, 31));
      @(negedge clk);
      chk("R7", "hold while busy", 64'(fetch_hold_o), 64'd1);
      chk("R7", "wait drain", 64'(redirect_o), 64'd0);
    end
    busy_i = 5'd0;
    @(negedge clk);
    chk("R8", "redirect", 64'(redirect_o), 64'd1);
    chk("R8", "cause", 64'(cause_o), 64'd4);
    chk("R8", "epc", 64'(epc_o), 64'(rpc));
    chk("R8", "ack", 64'(irq_ack_o), 64'd1);
    chk("R8", "hold low", 64'(fetch_hold_o), 64'd0);
    chk("R8", "wr_en", 64'(wr_en_o), 64'd1);
    chk("R8", "flush", 64'(flush_o), 64'd0);
    irq_i = 1'b0;
    @(negedge clk);
    chk("R8", "ack pulse", 64'(irq_ack_o), 64'd0);
    chk("R8", "hold stays low", 64'(fetch_hold_o), 64'd0);
  endtask

  // R9: fault wins over interrupt, during drain or in the same cycle
  task automatic irq_fault_trial(input bit in_drain, input logic [3:0] f);
    logic [31:0] pcs [4];
    int s;
    s = deepest(f);
    @(negedge clk);
    irq_i = 1'b1;
    busy_i = 5'b01110;
    if (in_drain) begin
      @(negedge clk);
      chk("R9", "draining", 64'(fetch_hold_o), 64'd1);
    end
    fill_pcs(pcs);
    fault_i = f;
    @(negedge clk);
    chk("R9", "redirect", 64'(redirect_o), 64'd1);
    chk("R9", "cause", 64'(cause_o), 64'(s));
    chk("R9", "epc", 64'(epc_o), 64'(pcs[s]));
    chk("R9", "hold low", 64'(fetch_hold_o), 64'd0);
    chk("R9", "no ack", 64'(irq_ack_o), 64'd0);
    fault_i = 4'd0;
    irq_i = 1'b0;
    busy_i = 5'd0;
    repeat (4 - s) @(negedge clk);
    chk("R9", "wr_en back", 64'(wr_en_o), 64'd1);
    chk("R9", "hold stays low", 64'(fetch_hold_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    fault_i = 4'd0;
    stage_pc_i = '0;
    busy_i = 5'd0;
    resume_pc_i = '0;
    irq_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "redirect in reset", 64'(redirect_o), 64'd0);
    chk("R1", "wr_en in reset", 64'(wr_en_o), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "redirect", 64'(redirect_o), 64'd0);
    chk("R1", "flush", 64'(flush_o), 64'd0);
    chk("R1", "ack", 64'(irq_ack_o), 64'd0);
    chk("R1", "hold", 64'(fetch_hold_o), 64'd0);
    chk("R1", "epc", 64'(epc_o), 64'd0);
    chk("R1", "cause", 64'(cause_o), 64'd0);
    chk("R1", "wr_en", 64'(wr_en_o), 64'd1);

    for (int i = 0; i < 4; i++) fault_trial(4'(1 << i), 1'b0);
    fault_trial(4'b1111, 1'b0);
    fault_trial(4'b0110, 1'b1);
    fault_trial(4'b0011, 1'b1);
    for (int i = 0; i < 60; i++) fault_trial(4'($urandom_range(1, 15)), 1'b1);

    irq_trial(0);
    irq_trial(1);
    irq_trial(5);
    irq_fault_trial(1'b1, 4'b0100);
    irq_fault_trial(1'b0, 4'b0010);
    for (int i = 0; i < 10; i++) begin
      irq_trial($urandom_range(0, 6));
      fault_trial(4'($urandom_range(1, 15)), 1'b1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule